// File: doc/BRIEF.md
# Booth-Recoded Signed Multiplier with Weighted Row Gathering

This block multiplies two N-bit two's-complement operands and returns their exact 2N-bit signed product. The multiplier operand `b` is recoded into signed Booth digits at a radix chosen at elaboration time. Radix 4 gives digits in {-2..+2}. Radix 8 gives digits in {-4..+4}. The 3X multiple needed at radix 8 is built with one extra adder as 2X + X. Each digit picks a multiple of the multiplicand `a`. That multiple is sign-extended to the full product width to form one partial-product row. Every row is then placed at its weight (2 bits per digit at radix 4, 3 bits at radix 8) and summed into the product.

The datapath is purely combinational. An optional output register (`REG_OUT`) captures the product on the rising clock edge whenever `in_valid` is high. It presents `out_valid` one cycle after the inputs. Supported operand widths are 4, 8 and 16 bits. Any other width or radix stops elaboration.

Top module: `booth_xc_mul`

## Requirements
- R1: With RADIX=4, `product` equals the exact two's-complement product of `a` and `b`, taken to 2N bits, for every input pair. The radix-4 digits are formed from bit triples (b[2j+1], b[2j], b[2j-1]), with b[-1]=0, as -2*b[2j+1] + b[2j] + b[2j-1].
- R2: With RADIX=8, `product` equals the exact two's-complement product for every input pair. The radix-8 digits are formed from bit quads (b[3j+2], b[3j+1], b[3j], b[3j-1]) of the sign-extended multiplier, with b[-1]=0, as -4*b[3j+2] + 2*b[3j+1] + b[3j] + b[3j-1].
- R3: At RADIX=8, multipliers that produce a digit of +3 or -3 (for example b=3, b=-3 and b=24) give products of exactly that digit's multiple of `a`.
- R4: The most-negative value times itself gives +2^(2N-2), with no sign error.
- R5: With REG_OUT=1, an active reset (`rst_n`=0) clears `product` and `out_valid` to 0. Afterwards `out_valid` on each cycle equals `in_valid` of the previous cycle, and `product` belongs to the inputs presented in that previous cycle.
- R6: With REG_OUT=1, a clock edge with `in_valid`=0 leaves `product` unchanged.
- R7: With REG_OUT=0, `product` follows `a` and `b` without a clock edge, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `a` and `b`; loads the output register |
| a | input | N | Multiplicand, two's complement |
| b | input | N | Multiplier, two's complement, Booth-recoded |
| out_valid | output | 1 | Product qualifier |
| product | output | 2N | Signed product |

## Verification
The bench builds six copies of the block:
- N=4 at both radices, one of them without the output register.
- N=8 at both radices.
- N=16 at both radices.

At N=4 and N=8, every operand pair is reachable, so each digit pattern, including the top group that needs sign extension, is covered exhaustively. At N=16, random pairs together with a grid of extreme values cover the wide carry paths. Directed cases cover the ±3 hard multiple, the most-negative square, the hold behaviour when `in_valid` is low, and the unregistered variant changing between clock edges.

// File: rtl/bxm_pkg.sv
package bxm_pkg;
   localparam int DIGIT_W = 4;   // signed digit, range -4..+4

   function automatic int digit_shift(int radix);
      return (radix == 8) ? 3 : 2;
   endfunction

   function automatic int group_count(int n, int radix);
      return (radix == 8) ? (n + 2) / 3 : (n + 1) / 2;
   endfunction
endpackage

// File: rtl/bxm_recoder.sv
module bxm_recoder #(
   parameter int N     = 8,
   parameter int RADIX = 4,
   localparam int S    = bxm_pkg::digit_shift(RADIX),
   localparam int G    = bxm_pkg::group_count(N, RADIX),
   localparam int DW   = bxm_pkg::DIGIT_W
) (
   input  logic [N-1:0]    b,
   output logic [G*DW-1:0] digits
);
   // extended multiplier: sign bits on top, appended zero below bit 0
   localparam int EW = S*G + 2;
   logic [EW-1:0] ext;
   assign ext = {{(EW-1-N){b[N-1]}}, b, 1'b0};

   for (genvar j = 0; j < G; j++) begin : g_grp
      logic [S:0]           win;
      logic signed [DW-1:0] d;
      assign win = ext[S*j +: S+1];
      if (RADIX == 8) begin : g_r8
         always_comb begin
            d = -$signed({1'b0, win[3], 2'b00})
              + $signed({2'b00, win[2], 1'b0})
              + $signed({3'b000, win[1]})
              + $signed({3'b000, win[0]});
         end
      end else begin : g_r4
         always_comb begin
            d = -$signed({2'b00, win[2], 1'b0})
              + $signed({3'b000, win[1]})
              + $signed({3'b000, win[0]});
         end
      end
      assign digits[j*DW +: DW] = d;
   end
endmodule

// File: rtl/bxm_row.sv
module bxm_row #(
   parameter int N     = 8,
   parameter int RADIX = 4,
   localparam int W    = 2*N,
   localparam int DW   = bxm_pkg::DIGIT_W
) (
   input  logic [N-1:0]  a,
   input  logic [DW-1:0] digit,
   output logic [W-1:0]  row
);
   logic [W-1:0] ax, x2, x4, sel;
   logic         neg;
   logic [2:0]   mag;

   assign ax  = {{N{a[N-1]}}, a};
   assign x2  = ax << 1;
   assign x4  = ax << 2;
   assign neg = digit[DW-1];
   assign mag = neg ? 3'(~digit[2:0] + 3'd1) : digit[2:0];

   if (RADIX == 8) begin : g_r8
      logic [W-1:0] x3;
      assign x3 = x2 + ax;           // hard multiple
      always_comb begin
         case (mag)
            3'd1:    sel = ax;
            3'd2:    sel = x2;
            3'd3:    sel = x3;
            3'd4:    sel = x4;
            default: sel = '0;
         endcase
      end
   end else begin : g_r4
      always_comb begin
         case (mag)
            3'd1:    sel = ax;
            3'd2:    sel = x2;
            default: sel = '0;
         endcase
      end
   end

   assign row = neg ? (~sel + W'(1)) : sel;
endmodule

// File: rtl/bxm_sum.sv
module bxm_sum #(
   parameter int W = 16,
   parameter int G = 4,
   parameter int S = 2
) (
   input  logic [G*W-1:0] rows,
   output logic [W-1:0]   total
);
   // each row is already full width; align by digit weight and accumulate
   logic [W-1:0] acc [G+1];
   assign acc[0] = '0;
   for (genvar j = 0; j < G; j++) begin : g_acc
      logic [W-1:0] aligned;
      assign aligned  = rows[j*W +: W] << (S*j);
      assign acc[j+1] = acc[j] + aligned;
   end
   assign total = acc[G];
endmodule

// File: rtl/booth_xc_mul.sv
module booth_xc_mul #(
   parameter int N       = 16,
   parameter int RADIX   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic           out_valid,
   output logic [2*N-1:0] product
);
   localparam int W  = 2*N;
   localparam int S  = bxm_pkg::digit_shift(RADIX);
   localparam int G  = bxm_pkg::group_count(N, RADIX);
   localparam int DW = bxm_pkg::DIGIT_W;

   if (!(N == 4 || N == 8 || N == 16)) begin : g_bad_width
      $error("booth_xc_mul: N must be 4, 8 or 16");
   end
   if (!(RADIX == 4 || RADIX == 8)) begin : g_bad_radix
      $error("booth_xc_mul: RADIX must be 4 or 8");
   end

   logic [G*DW-1:0] digits;
   logic [G*W-1:0]  rows;
   logic [W-1:0]    sum;

   bxm_recoder #(.N(N), .RADIX(RADIX)) u_rec (
      .b      (b),
      .digits (digits)
   );

   for (genvar j = 0; j < G; j++) begin : g_row
      bxm_row #(.N(N), .RADIX(RADIX)) u_row (
         .a     (a),
         .digit (digits[j*DW +: DW]),
         .row   (rows[j*W +: W])
      );
   end

   bxm_sum #(.W(W), .G(G), .S(S)) u_sum (
      .rows  (rows),
      .total (sum)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) product <= sum;
         end
      end
   end else begin : g_comb
      assign out_valid = in_valid;
      assign product   = sum;
   end
endmodule

// File: rtl/bxm_check.sv
module bxm_check #(
   parameter int N       = 16,
   parameter int RADIX   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic [N-1:0]   a,
   input logic [N-1:0]   b,
   input logic           out_valid,
   input logic [2*N-1:0] product
);
   localparam int W = 2*N;
   localparam logic [N-1:0] MINV  = {1'b1, {(N-1){1'b0}}};
   localparam logic [W-1:0] MINSQ = W'(1) << (W-2);

   function automatic logic [W-1:0] golden(logic [N-1:0] x, logic [N-1:0] y);
      logic signed [W-1:0] xs, ys;
      xs = {{N{x[N-1]}}, x};
      ys = {{N{y[N-1]}}, y};
      return W'(xs * ys);
   endfunction

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   if (REG_OUT) begin : g_reg
      assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> (out_valid == $past(in_valid)));
      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && !$past(in_valid)) |-> (product == $past(product)));
      assert_minsq_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && $past(in_valid) && $past(a) == MINV && $past(b) == MINV)
         |-> (product == MINSQ));
      if (RADIX == 4) begin : g_r4
         assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(in_valid)) |-> (product == golden($past(a), $past(b))));
      end else begin : g_r8
         assert_product_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(in_valid)) |-> (product == golden($past(a), $past(b))));
         assert_hard_three_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(in_valid) && $past(b) == N'(3))
            |-> (product == W'(3 * $signed({{N{$past(a[N-1])}}, $past(a)}))));
      end
   end else begin : g_comb
      assert_comb_R7: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> (product == golden(a, b)));
      assert_minsq_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (a == MINV && b == MINV) |-> (product == MINSQ));
   end
endmodule

bind booth_xc_mul bxm_check #(.N(N), .RADIX(RADIX), .REG_OUT(REG_OUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .a         (a),
   .b         (b),
   .out_valid (out_valid),
   .product   (product)
);

// File: tb/booth_xc_mul_test.sv
module booth_xc_mul_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;
   logic rst_n = 1'b0;

   logic [3:0]  a4 = '0, b4 = '0;
   logic [7:0]  a8 = '0, b8 = '0;
   logic [15:0] a16 = '0, b16 = '0;
   logic        v4 = 1'b0, v8 = 1'b0, v16 = 1'b0;

   logic [7:0]  p4r4, p4r8;
   logic [15:0] p8r4, p8r8;
   logic [31:0] p16r4, p16r8;
   logic        o4r4, o4r8, o8r4, o8r8, o16r4, o16r8;

   int total = 0;
   int fails = 0;

   booth_xc_mul #(.N(16), .RADIX(8), .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(v16), .a(a16), .b(b16),
      .out_valid(o16r8), .product(p16r8));
   booth_xc_mul #(.N(16), .RADIX(4), .REG_OUT(1'b1)) u16r4 (
      .clk(clk), .rst_n(rst_n), .in_valid(v16), .a(a16), .b(b16),
      .out_valid(o16r4), .product(p16r4));
   booth_xc_mul #(.N(8), .RADIX(4), .REG_OUT(1'b1)) u8r4 (
      .clk(clk), .rst_n(rst_n), .in_valid(v8), .a(a8), .b(b8),
      .out_valid(o8r4), .product(p8r4));
   booth_xc_mul #(.N(8), .RADIX(8), .REG_OUT(1'b1)) u8r8 (
      .clk(clk), .rst_n(rst_n), .in_valid(v8), .a(a8), .b(b8),
      .out_valid(o8r8), .product(p8r8));
   booth_xc_mul #(.N(4), .RADIX(4), .REG_OUT(1'b0)) u4r4 (
      .clk(clk), .rst_n(rst_n), .in_valid(v4), .a(a4), .b(b4),
      .out_valid(o4r4), .product(p4r4));
   booth_xc_mul #(.N(4), .RADIX(8), .REG_OUT(1'b1)) u4r8 (
      .clk(clk), .rst_n(rst_n), .in_valid(v4), .a(a4), .b(b4),
      .out_valid(o4r8), .product(p4r8));

   function automatic logic [31:0] smul(int n, logic [15:0] x, logic [15:0] y);
      int xi, yi;
      logic [31:0] m;
      xi = x[n-1] ? int'(x & 16'((1 << n) - 1)) - (1 << n) : int'(x & 16'((1 << n) - 1));
      yi = y[n-1] ? int'(y & 16'((1 << n) - 1)) - (1 << n) : int'(y & 16'((1 << n) - 1));
      m  = (n == 16) ? 32'hFFFF_FFFF : 32'((64'd1 << (2*n)) - 64'd1);
      return 32'(xi * yi) & m;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(logic [3:0] x4, logic [3:0] y4, logic [7:0] x8, logic [7:0] y8,
                       logic [15:0] x16, logic [15:0] y16, logic v);
      @(negedge clk);
      a4 = x4; b4 = y4; a8 = x8; b8 = y8; a16 = x16; b16 = y16;
      v4 = v; v8 = v; v16 = v;
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   task automatic t_reset();
      #1;
      chk("R5 reset product", p16r8, 32'h0);
      chk("R5 reset valid", 32'(o16r8), 32'h0);
      chk("R5 reset product r4", p16r4, 32'h0);
      chk("R5 reset valid n8", 32'({o8r4, o8r8, o4r8}), 32'h0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_exh4();
      for (int i = 0; i < 256; i++) begin
         step(4'(i >> 4), 4'(i), a8, b8, a16, b16, 1'b1);
         chk("R1 n4 exhaustive", 32'(p4r4), smul(4, 16'(i >> 4), 16'(i & 15)));
         chk("R2 n4 exhaustive", 32'(p4r8), smul(4, 16'(i >> 4), 16'(i & 15)));
      end
   endtask

   task automatic t_exh8();
      for (int i = 0; i < 65536; i++) begin
         step(a4, b4, 8'(i >> 8), 8'(i), a16, b16, 1'b1);
         chk("R1 n8 exhaustive", 32'(p8r4), smul(8, 16'(i >> 8), 16'(i & 255)));
         chk("R2 n8 exhaustive", 32'(p8r8), smul(8, 16'(i >> 8), 16'(i & 255)));
      end
   endtask

   task automatic t_wide();
      logic [15:0] corner [6] = '{16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h0001, 16'h5555};
      for (int i = 0; i < 6; i++) begin
         for (int k = 0; k < 6; k++) begin
            step(a4, b4, a8, b8, corner[i], corner[k], 1'b1);
            chk("R1 n16 corner", p16r4, smul(16, corner[i], corner[k]));
            chk("R2 n16 corner", p16r8, smul(16, corner[i], corner[k]));
         end
      end
      for (int i = 0; i < 100000; i++) begin
         logic [15:0] x, y;
         x = 16'($urandom);
         y = 16'($urandom);
         step(a4, b4, a8, b8, x, y, 1'b1);
         chk("R1 n16 random", p16r4, smul(16, x, y));
         chk("R2 n16 random", p16r8, smul(16, x, y));
      end
   endtask

   task automatic t_hard3();
      logic [15:0] mults [4] = '{16'h0003, 16'hFFFD, 16'h0018, 16'hFFE8};
      logic [15:0] cands [3] = '{16'h7FFF, 16'h8000, 16'h1234};
      for (int i = 0; i < 4; i++) begin
         for (int k = 0; k < 3; k++) begin
            step(4'(cands[k]), 4'(mults[i]), 8'(cands[k]), 8'(mults[i]),
                 cands[k], mults[i], 1'b1);
            chk("R3 hard multiple n16", p16r8, smul(16, cands[k], mults[i]));
            chk("R3 hard multiple n8", 32'(p8r8), smul(8, cands[k], mults[i]));
            chk("R3 hard multiple n4", 32'(p4r8), smul(4, cands[k], mults[i]));
         end
      end
   endtask

   task automatic t_minsq();
      step(4'h8, 4'h8, 8'h80, 8'h80, 16'h8000, 16'h8000, 1'b1);
      chk("R4 min square n16 r8", p16r8, 32'h4000_0000);
      chk("R4 min square n16 r4", p16r4, 32'h4000_0000);
      chk("R4 min square n8 r4", 32'(p8r4), 32'h4000);
      chk("R4 min square n8 r8", 32'(p8r8), 32'h4000);
      chk("R4 min square n4 r4", 32'(p4r4), 32'h40);
      chk("R4 min square n4 r8", 32'(p4r8), 32'h40);
   endtask

   task automatic t_hold();
      step(a4, b4, a8, b8, 16'd1234, 16'd5, 1'b1);
      chk("R6 load", p16r8, 32'd6170);
      for (int i = 0; i < 3; i++) begin
         step(a4, b4, a8, b8, 16'(999 + i), 16'(7 + i), 1'b0);
         chk("R6 hold product", p16r8, 32'd6170);
         chk("R6 hold product r4", p16r4, 32'd6170);
      end
   endtask

   task automatic t_valid();
      logic pat [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      for (int i = 0; i < 6; i++) begin
         step(a4, b4, a8, b8, 16'(i + 3), 16'hFFF0, pat[i]);
         chk("R5 valid delay", 32'(o16r8), 32'(pat[i]));
         if (pat[i]) chk("R5 product timing", p16r8, smul(16, 16'(i + 3), 16'hFFF0));
      end
      @(negedge clk);
      v16 = 1'b0;
      @(posedge clk);
      #1;
      chk("R5 valid drop", 32'(o16r8), 32'h0);
   endtask

   task automatic t_comb();
      @(negedge clk);
      a4 = 4'hD; b4 = 4'h5; v4 = 1'b1;
      #1;
      chk("R7 comb product", 32'(p4r4), 32'h0000_00F1);
      chk("R7 comb valid", 32'(o4r4), 32'h1);
      a4 = 4'h7; b4 = 4'h8; v4 = 1'b0;
      #1;
      chk("R7 comb product change", 32'(p4r4), 32'h0000_00C8);
      chk("R7 comb valid low", 32'(o4r4), 32'h0);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      fails++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_comb();
      t_minsq();
      t_hard3();
      t_hold();
      t_valid();
      t_exh4();
      t_exh8();
      t_wide();
      summary();
      $finish;
   end
endmodule